// File: doc/BRIEF.md
# Kernel-Mode Virtual Address Segment Decoder

This block sorts a 32-bit virtual address, issued while the core runs with privileged rights, into one of five address windows. The upper three address bits and the processor's mode bits select the window. For each request it reports four things one cycle later:
- whether the access must be looked up in the translation buffer;
- whether the access may be cached;
- for the windows that bypass translation, the physical address;
- for translated accesses, a lookup tag that joins the address-space identifier to the virtual address.

A request made without privileged rights, or with wide (64-bit) addressing selected, is flagged as an error. Such a request yields neither a lookup nor a cacheable access.

The block sits between the address generation stage and the translation buffer. A pipeline presents one address per cycle with `req_vld` high and takes the registered result when `out_vld` is high.

Top module: `kva_seg_decode`

## Requirements
- R1: Each cycle with `req_vld` high produces exactly one result, with `out_vld` high on the next clock edge. `out_vld` is low in every cycle after a cycle without a request.
- R2: Privileged mode holds when `st_ksu` is 2'b00, or `st_exl` is 1, or `st_erl` is 1. A request outside privileged mode sets `out_err` to 1.
- R3: A request with `st_kx` = 1 sets `out_err` to 1. When `out_err` is 1, `out_mapped`, `out_cached`, `out_paddr` and `out_tag` are all 0, and `out_seg` still gives the window decoded from the address.
- R4: Address bit 31 = 0 with `st_erl` = 0 selects the user window. For this window `out_seg` = 0, `out_mapped` = 1, `out_cached` = 0 and `out_paddr` = 0.
- R5: For every translated access, `out_tag` = {`asid`, `vaddr`} (40 bits, identifier in bits 39:32). For every untranslated access, `out_tag` is 0.
- R6: Address bit 31 = 0 with `st_erl` = 1 selects the user window (`out_seg` = 0) as an untranslated, uncached identity window: `out_paddr` = `vaddr`.
- R7: Bits 31..29 = 3'b100 select window 1, which is untranslated. `out_paddr` = `vaddr` − 0x8000_0000. `out_cached` is 0 when `cfg_k0` = 3'b010 and 1 for every other `cfg_k0` value.
- R8: Bits 31..29 = 3'b101 select window 2, which is untranslated and uncached. `out_paddr` = {3'b000, `vaddr`[28:0]}.
- R9: Bits 31..29 = 3'b110 select window 3, and 3'b111 select window 4. Both are translated and uncached, with `out_paddr` = 0.
- R10: While `rst_n` is low, every output is 0. In cycles without a request, `out_seg`, the flags, `out_paddr` and `out_tag` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_vld | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| st_ksu | input | 2 | Mode field from the status register |
| st_exl | input | 1 | Exception-level bit |
| st_erl | input | 1 | Error-level bit |
| st_kx | input | 1 | Wide-addressing enable |
| asid | input | 8 | Address-space identifier |
| cfg_k0 | input | 3 | Cacheability code for window 1 |
| out_vld | output | 1 | Result valid |
| out_seg | output | 3 | Window code 0..4 |
| out_mapped | output | 1 | Translation lookup required |
| out_cached | output | 1 | Access may be cached |
| out_paddr | output | 32 | Physical address of an untranslated access |
| out_tag | output | 40 | Lookup tag of a translated access |
| out_err | output | 1 | Request outside privileged 32-bit addressing |

## Verification
Every result is due exactly one clock edge after the cycle in which its request is presented, because the only storage on the path is one output register stage. The driver presents each request at a falling edge and queues the expected result at the same moment. The monitor wakes shortly after each rising edge, and each time `out_vld` is high it takes one expected item from the queue. A result that arrives early, late, or without a request therefore shows up as a queue mismatch. The hold check samples several idle cycles after the last response, against the last expected value.

// File: rtl/kva_pkg.sv
package kva_pkg;
  typedef enum logic [2:0] {
    SEG_USER = 3'd0,
    SEG_K0   = 3'd1,
    SEG_K1   = 3'd2,
    SEG_KS   = 3'd3,
    SEG_K3   = 3'd4
  } seg_e;

  typedef struct packed {
    seg_e seg;
    logic mapped;
    logic cached;
    logic err;
  } cls_t;
endpackage

// File: rtl/kva_mode_chk.sv
module kva_mode_chk (
  input  logic [1:0] st_ksu,
  input  logic       st_exl,
  input  logic       st_erl,
  input  logic       st_kx,
  output logic       err
);
  logic priv;

  always_comb begin
    priv = (st_ksu == 2'b00) | st_exl | st_erl;
    err  = ~priv | st_kx;
  end
endmodule

// File: rtl/kva_seg_class.sv
module kva_seg_class
  import kva_pkg::*;
#(
  parameter int          K0_W   = 3,
  parameter logic [2:0]  K0_UNC = 3'b010
) (
  input  logic [2:0]      va_hi,
  input  logic            st_erl,
  input  logic            err,
  input  logic [K0_W-1:0] cfg_k0,
  output cls_t            cls
);
  always_comb begin
    cls = '0;
    cls.err = err;
    unique casez (va_hi)
      3'b0??:  cls.seg = SEG_USER;
      3'b100:  cls.seg = SEG_K0;
      3'b101:  cls.seg = SEG_K1;
      3'b110:  cls.seg = SEG_KS;
      default: cls.seg = SEG_K3;
    endcase
    if (!err) begin
      case (cls.seg)
        SEG_USER: cls.mapped = ~st_erl;
        SEG_K0:   cls.cached = (cfg_k0 != K0_W'(K0_UNC));
        SEG_KS,
        SEG_K3:   cls.mapped = 1'b1;
        default:  cls.mapped = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/kva_xlate.sv
module kva_xlate
  import kva_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int ASID_W = 8
) (
  input  logic [VA_W-1:0]        vaddr,
  input  logic [ASID_W-1:0]      asid,
  input  cls_t                   cls,
  output logic [VA_W-1:0]        paddr,
  output logic [ASID_W+VA_W-1:0] tag
);
  localparam int WIN_W = VA_W - 3;

  always_comb begin
    paddr = '0;
    tag   = '0;
    if (!cls.err) begin
      if (cls.mapped) begin
        tag = {asid, vaddr};
      end else begin
        case (cls.seg)
          SEG_USER:      paddr = vaddr;
          SEG_K0, SEG_K1: paddr = {3'b000, vaddr[WIN_W-1:0]};
          default:       paddr = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/kva_seg_decode.sv
module kva_seg_decode
  import kva_pkg::*;
#(
  parameter int         VA_W   = 32,
  parameter int         ASID_W = 8,
  parameter int         K0_W   = 3,
  parameter logic [2:0] K0_UNC = 3'b010
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_vld,
  input  logic [VA_W-1:0]        vaddr,
  input  logic [1:0]             st_ksu,
  input  logic                   st_exl,
  input  logic                   st_erl,
  input  logic                   st_kx,
  input  logic [ASID_W-1:0]      asid,
  input  logic [K0_W-1:0]        cfg_k0,
  output logic                   out_vld,
  output logic [2:0]             out_seg,
  output logic                   out_mapped,
  output logic                   out_cached,
  output logic [VA_W-1:0]        out_paddr,
  output logic [ASID_W+VA_W-1:0] out_tag,
  output logic                   out_err
);
  localparam int TAG_W = ASID_W + VA_W;

  logic             err_w;
  cls_t             cls_w;
  logic [VA_W-1:0]  paddr_w;
  logic [TAG_W-1:0] tag_w;

  kva_mode_chk u_mode (
    .st_ksu (st_ksu),
    .st_exl (st_exl),
    .st_erl (st_erl),
    .st_kx  (st_kx),
    .err    (err_w)
  );

  kva_seg_class #(.K0_W(K0_W), .K0_UNC(K0_UNC)) u_class (
    .va_hi  (vaddr[VA_W-1 -: 3]),
    .st_erl (st_erl),
    .err    (err_w),
    .cfg_k0 (cfg_k0),
    .cls    (cls_w)
  );

  kva_xlate #(.VA_W(VA_W), .ASID_W(ASID_W)) u_xlate (
    .vaddr (vaddr),
    .asid  (asid),
    .cls   (cls_w),
    .paddr (paddr_w),
    .tag   (tag_w)
  );

  // output register stage: next-state logic
  logic             vld_q, vld_d;
  cls_t             cls_q, cls_d;
  logic [VA_W-1:0]  pa_q, pa_d;
  logic [TAG_W-1:0] tag_q, tag_d;

  always_comb begin
    vld_d = req_vld;
    cls_d = cls_q;
    pa_d  = pa_q;
    tag_d = tag_q;
    if (req_vld) begin
      cls_d = cls_w;
      pa_d  = paddr_w;
      tag_d = tag_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cls_q <= '0;
      pa_q  <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= vld_d;
      cls_q <= cls_d;
      pa_q  <= pa_d;
      tag_q <= tag_d;
    end
  end

  assign out_vld    = vld_q;
  assign out_seg    = cls_q.seg;
  assign out_mapped = cls_q.mapped;
  assign out_cached = cls_q.cached;
  assign out_err    = cls_q.err;
  assign out_paddr  = pa_q;
  assign out_tag    = tag_q;
endmodule

// File: rtl/kva_seg_decode_chk.sv
module kva_seg_decode_chk #(
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int K0_W   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_vld,
  input logic [VA_W-1:0]        vaddr,
  input logic [1:0]             st_ksu,
  input logic                   st_exl,
  input logic                   st_erl,
  input logic                   st_kx,
  input logic [ASID_W-1:0]      asid,
  input logic [K0_W-1:0]        cfg_k0,
  input logic                   out_vld,
  input logic [2:0]             out_seg,
  input logic                   out_mapped,
  input logic                   out_cached,
  input logic [VA_W-1:0]        out_paddr,
  input logic [ASID_W+VA_W-1:0] out_tag,
  input logic                   out_err
);
  AST_REQ_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> out_vld); // R1
  AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !out_vld); // R1
  AST_KX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && st_kx) |=> out_err); // R3
  AST_USER_MODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && st_ksu != 2'b00 && !st_exl && !st_erl) |=> out_err); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_err) |-> (!out_mapped && !out_cached && out_paddr == '0 && out_tag == '0)); // R3
  AST_MAPPED_NO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_mapped) |-> (out_paddr == '0 && !out_cached)); // R9
  AST_K1_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_seg == 3'd2) |-> !out_cached); // R8
  AST_UNMAPPED_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_mapped) |-> out_tag == '0); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(out_seg) && $stable(out_paddr) && $stable(out_tag))); // R10
endmodule

bind kva_seg_decode kva_seg_decode_chk #(.VA_W(VA_W), .ASID_W(ASID_W), .K0_W(K0_W)) u_chk (.*);

// File: tb/sim_kva_seg_decode.sv
module sim_kva_seg_decode;
  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic [31:0] vaddr;
  logic [1:0]  st_ksu;
  logic        st_exl, st_erl, st_kx;
  logic [7:0]  asid;
  logic [2:0]  cfg_k0;
  logic        out_vld;
  logic [2:0]  out_seg;
  logic        out_mapped, out_cached, out_err;
  logic [31:0] out_paddr;
  logic [39:0] out_tag;

  typedef struct packed {
    logic [2:0]  seg;
    logic        m;
    logic        c;
    logic        e;
    logic [31:0] pa;
    logic [39:0] tag;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  last_exp;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  kva_seg_decode u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .vaddr(vaddr),
    .st_ksu(st_ksu), .st_exl(st_exl), .st_erl(st_erl), .st_kx(st_kx),
    .asid(asid), .cfg_k0(cfg_k0), .out_vld(out_vld), .out_seg(out_seg),
    .out_mapped(out_mapped), .out_cached(out_cached), .out_paddr(out_paddr),
    .out_tag(out_tag), .out_err(out_err)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic exp_t model(input logic [31:0] va, input logic [1:0] ksu,
                                 input logic exl, input logic erl, input logic kx,
                                 input logic [7:0] id, input logic [2:0] k0);
    exp_t r;
    r = '0;
    r.e = !((ksu == 2'b00) || exl || erl) || kx;             // R2, R3
    if (!va[31])                 r.seg = 3'd0;
    else if (va[30:29] == 2'b00) r.seg = 3'd1;
    else if (va[30:29] == 2'b01) r.seg = 3'd2;
    else if (va[30:29] == 2'b10) r.seg = 3'd3;
    else                         r.seg = 3'd4;
    if (!r.e) begin
      case (r.seg)
        3'd0: if (erl) r.pa = va; else r.m = 1;               // R4, R6
        3'd1: begin r.pa = va - 32'h8000_0000; r.c = (k0 != 3'b010); end // R7
        3'd2: r.pa = va & 32'h1FFF_FFFF;                      // R8
        default: r.m = 1;                                     // R9
      endcase
      if (r.m) r.tag = {id, va};                              // R5
    end
    return r;
  endfunction

  task automatic send(input logic [31:0] va, input logic [1:0] ksu, input logic exl,
                      input logic erl, input logic kx, input logic [7:0] id,
                      input logic [2:0] k0, input string rq);
    @(negedge clk);
    req_vld = 1; vaddr = va; st_ksu = ksu; st_exl = exl; st_erl = erl;
    st_kx = kx; asid = id; cfg_k0 = k0;
    last_exp = model(va, ksu, exl, erl, kx, id, k0);
    exp_q.push_back(last_exp);
    tag_q.push_back(rq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 0;
      vaddr = ~vaddr;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && out_vld) begin
      exp_t  e;
      string rq;
      exp_t  a;
      a = {out_seg, out_mapped, out_cached, out_err, out_paddr, out_tag};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected result actual=%h expected=none", a);
      end else begin
        e  = exp_q.pop_front();
        rq = tag_q.pop_front();
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual seg=%0d m=%b c=%b e=%b pa=%h tag=%h expected seg=%0d m=%b c=%b e=%b pa=%h tag=%h",
                   rq, a.seg, a.m, a.c, a.e, a.pa, a.tag, e.seg, e.m, e.c, e.e, e.pa, e.tag);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 0; req_vld = 0; vaddr = 0; st_ksu = 0; st_exl = 0; st_erl = 0;
    st_kx = 0; asid = 0; cfg_k0 = 0;
    repeat (3) @(negedge clk);
    checks++;                                                   // R10 reset state
    if ({out_vld, out_seg, out_mapped, out_cached, out_err, out_paddr, out_tag} !== '0) begin
      errors++;
      $display("FAIL R10 reset actual=%b/%h/%h expected=0", out_vld, out_paddr, out_tag);
    end
    rst_n = 1;
    // user window, privileged via each condition
    send(32'h0000_1234, 2'b00, 0, 0, 0, 8'h5A, 3'd3, "R4 user ksu00");
    send(32'h7FFF_FFFF, 2'b10, 1, 0, 0, 8'hC3, 3'd3, "R5 user exl tag");
    send(32'h1234_5678, 2'b10, 0, 1, 0, 8'h11, 3'd3, "R6 user erl identity");
    send(32'h7FFF_FFFF, 2'b00, 0, 1, 0, 8'h22, 3'd3, "R6 erl top of window");
    // window 1
    send(32'h8000_0000, 2'b00, 0, 0, 0, 8'h01, 3'd3, "R7 k0 base cached");
    send(32'h9FFF_FFFF, 2'b00, 0, 0, 0, 8'h01, 3'b010, "R7 k0 top uncached code");
    send(32'h8ABC_DEF0, 2'b00, 0, 0, 0, 8'h01, 3'd0, "R7 k0 code 0 cached");
    // window 2
    send(32'hA000_0000, 2'b00, 0, 0, 0, 8'h01, 3'd3, "R8 k1 base");
    send(32'hBFFF_FFFF, 2'b00, 1, 0, 0, 8'h01, 3'd3, "R8 k1 top");
    // windows 3 and 4
    send(32'hC000_0000, 2'b00, 0, 0, 0, 8'h7E, 3'd3, "R9 ks base");
    send(32'hDFFF_FFFF, 2'b00, 0, 0, 0, 8'h7E, 3'd3, "R9 ks top");
    send(32'hE000_0000, 2'b00, 0, 0, 0, 8'h99, 3'd3, "R9 k3 base");
    send(32'hFFFF_FFFF, 2'b00, 0, 1, 0, 8'h99, 3'd3, "R9 k3 top erl");
    // errors
    send(32'h8000_0010, 2'b01, 0, 0, 0, 8'h33, 3'd3, "R2 ksu01 error");
    send(32'h0000_0010, 2'b10, 0, 0, 0, 8'h33, 3'd3, "R2 ksu10 error");
    send(32'hC000_0010, 2'b00, 0, 0, 1, 8'h33, 3'd3, "R3 kx error");
    send(32'hA000_0010, 2'b00, 0, 1, 1, 8'h33, 3'd3, "R3 kx with erl");
    idle(2);
    // R1 spaced requests
    send(32'h0000_0040, 2'b00, 0, 0, 0, 8'h44, 3'd3, "R1 single after gap");
    idle(1);
    lf = 32'hACE1_2345;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send(lf, lf[5:4], lf[7], lf[9], (lf[12:10] == 3'b000), lf[23:16], lf[3:1], "R7 mixed stream");
    end
    idle(4);
    // R10 hold: outputs keep last result while idle
    checks++;
    if (out_vld !== 1'b0 ||
        {out_seg, out_mapped, out_cached, out_err, out_paddr, out_tag} !== last_exp) begin
      errors++;
      $display("FAIL R10 hold actual=%h vld=%b expected=%h", {out_seg, out_mapped,
               out_cached, out_err, out_paddr, out_tag}, out_vld, last_exp);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule